// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This block is the bitwise and flag section of a small 8-bit accumulator datapath. It holds the accumulator and a five-bit flag set: sign, zero, auxiliary carry, parity and carry. On each rising clock edge where the operation strobe is high, it runs one operation on the accumulator and the operand port. The operations are bitwise AND, OR and XOR, a compare, four single-bit rotates, complement accumulator, complement carry and set carry.

The operand arrives already selected. It may come from a register, from memory or from an immediate field; the block does not care which. Each operation has its own rule for which state it writes. Compare writes only the flags. The rotates write the accumulator and carry. Complement accumulator writes no flag. Because of this, a later branch or carry-chain step can depend on flags that earlier operations set.

Top module: `acc_logic_unit`

## Requirements
- R1: With `rst` high at a rising edge, the accumulator and all five flags become 0 on that edge.
- R2: When `op_valid` is low, or `op_code` is in the range 11..15, the accumulator and all flags keep their values.
- R3: Op codes 0 (AND), 1 (OR) and 2 (XOR) combine the accumulator with `operand` bit by bit and store the result in the accumulator.
- R4: After op codes 0, 1 and 2, carry is 0 and auxiliary carry is 1. Sign is bit 7 of the result. Zero is 1 when the result is 0x00. Parity is 1 when the result has an even number of 1 bits.
- R5: Op code 3 (compare) leaves the accumulator unchanged. It sets carry when the accumulator is smaller than `operand` (unsigned) and sets zero when the two are equal. When the accumulator is larger, both carry and zero are 0.
- R6: On compare, sign and parity are taken from the 8-bit difference, accumulator minus operand. Auxiliary carry is 1 when the low nibble of the accumulator is smaller than the low nibble of `operand`.
- R7: Op code 4 rotates left, copying bit 7 into both bit 0 and carry. Op code 5 rotates right, copying bit 0 into both bit 7 and carry.
- R8: Op code 6 rotates left through carry: bit 7 goes to carry and the old carry goes to bit 0. Op code 7 rotates right through carry: bit 0 goes to carry and the old carry goes to bit 7.
- R9: Op codes 4 to 7 leave sign, zero, parity and auxiliary carry unchanged.
- R10: Op code 8 inverts all accumulator bits and leaves every flag unchanged.
- R11: Op code 9 inverts carry and op code 10 sets carry to 1. Neither changes the accumulator or any other flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select, encoded as in R2 to R11 |
| operand | input | 8 | Second operand |
| acc_out | output | 8 | Accumulator |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Auxiliary carry flag |
| flag_p | output | 1 | Parity flag (even) |
| flag_cy | output | 1 | Carry flag |

## Verification
The checker tests every cycle that the strobe and the accumulator write enable act as a gate. It also checks that compare never moves the accumulator, that rotates and complement accumulator keep the flags they must keep, and that the bitwise results and forced flag values hold. The carry ordering through the through-carry rotates, the unsigned compare outcomes, and the half-borrow meaning of auxiliary carry are only shown by the bench's directed sequences. Those sequences feed chosen values and track the expected accumulator and flags from one operation to the next.

// File: rtl/acc_logic_pkg.sv
package acc_logic_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_CMP = 4'd3,
    OP_RLC = 4'd4,
    OP_RRC = 4'd5,
    OP_RAL = 4'd6,
    OP_RAR = 4'd7,
    OP_CMA = 4'd8,
    OP_CMC = 4'd9,
    OP_STC = 4'd10
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/bitwise_cmp_unit.sv
module bitwise_cmp_unit
  import acc_logic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [OPW-1:0]    op,
  output logic [DATA_W-1:0] logic_res,
  output logic [DATA_W-1:0] diff,
  output logic              borrow,
  output logic              half_borrow
);
  localparam int NIB = DATA_W / 2;

  logic [DATA_W:0] diff_wide;
  logic [NIB:0]    nib_wide;

  always_comb begin
    unique case (op)
      OP_AND:  logic_res = acc & opnd;
      OP_OR:   logic_res = acc | opnd;
      OP_XOR:  logic_res = acc ^ opnd;
      default: logic_res = acc;
    endcase
  end

  assign diff_wide   = {1'b0, acc} - {1'b0, opnd};
  assign nib_wide    = {1'b0, acc[NIB-1:0]} - {1'b0, opnd[NIB-1:0]};
  assign diff        = diff_wide[DATA_W-1:0];
  assign borrow      = diff_wide[DATA_W];
  assign half_borrow = nib_wide[NIB];
endmodule

// File: rtl/rotate_unit.sv
module rotate_unit
  import acc_logic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              cy_in,
  input  logic [OPW-1:0]    op,
  output logic [DATA_W-1:0] rot_res,
  output logic              rot_cy
);
  always_comb begin
    unique case (op)
      OP_RLC: begin
        rot_res = {acc[DATA_W-2:0], acc[DATA_W-1]};
        rot_cy  = acc[DATA_W-1];
      end
      OP_RRC: begin
        rot_res = {acc[0], acc[DATA_W-1:1]};
        rot_cy  = acc[0];
      end
      OP_RAL: begin
        rot_res = {acc[DATA_W-2:0], cy_in};
        rot_cy  = acc[DATA_W-1];
      end
      OP_RAR: begin
        rot_res = {cy_in, acc[DATA_W-1:1]};
        rot_cy  = acc[0];
      end
      default: begin
        rot_res = acc;
        rot_cy  = cy_in;
      end
    endcase
  end
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_logic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OPW-1:0]    op_code,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_out,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_ac,
  output logic              flag_p,
  output logic              flag_cy
);
  function automatic flags_t szp_of(input logic [DATA_W-1:0] v,
                                    input logic ac, input logic cy);
    flags_t f;
    f.s  = v[DATA_W-1];
    f.z  = (v == '0);
    f.p  = ~^v;
    f.ac = ac;
    f.cy = cy;
    return f;
  endfunction

  logic [DATA_W-1:0] acc_q, acc_d;
  flags_t            flg_q, flg_d;

  logic [DATA_W-1:0] logic_res, diff, rot_res;
  logic              borrow, half_borrow, rot_cy;

  // Decoded operation classes, brought out for the checker
  logic is_logic, is_cmp, is_rot, is_cma, is_cmc, is_stc;
  logic acc_we, flag_we;

  bitwise_cmp_unit #(.DATA_W(DATA_W)) u_bw (
    .acc(acc_q), .opnd(operand), .op(op_code),
    .logic_res(logic_res), .diff(diff),
    .borrow(borrow), .half_borrow(half_borrow)
  );

  rotate_unit #(.DATA_W(DATA_W)) u_rot (
    .acc(acc_q), .cy_in(flg_q.cy), .op(op_code),
    .rot_res(rot_res), .rot_cy(rot_cy)
  );

  assign is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
  assign is_cmp   = (op_code == OP_CMP);
  assign is_rot   = (op_code >= OP_RLC) && (op_code <= OP_RAR);
  assign is_cma   = (op_code == OP_CMA);
  assign is_cmc   = (op_code == OP_CMC);
  assign is_stc   = (op_code == OP_STC);

  assign acc_we  = op_valid && (is_logic || is_rot || is_cma);
  assign flag_we = op_valid && (is_logic || is_cmp || is_rot || is_cmc || is_stc);

  always_comb begin
    acc_d = acc_q;
    if (is_logic)     acc_d = logic_res;
    else if (is_rot)  acc_d = rot_res;
    else if (is_cma)  acc_d = ~acc_q;
  end

  always_comb begin
    flg_d = flg_q;
    if (is_logic) begin
      flg_d = szp_of(logic_res, 1'b1, 1'b0);
    end else if (is_cmp) begin
      flg_d = szp_of(diff, half_borrow, borrow);
    end else if (is_rot) begin
      flg_d.cy = rot_cy;
    end else if (is_cmc) begin
      flg_d.cy = ~flg_q.cy;
    end else if (is_stc) begin
      flg_d.cy = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      if (acc_we)  acc_q <= acc_d;
      if (flag_we) flg_q <= flg_d;
    end
  end

  assign acc_out = acc_q;
  assign flag_s  = flg_q.s;
  assign flag_z  = flg_q.z;
  assign flag_ac = flg_q.ac;
  assign flag_p  = flg_q.p;
  assign flag_cy = flg_q.cy;
endmodule

// File: rtl/acc_logic_unit_chk.sv
module acc_logic_unit_chk
  import acc_logic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [OPW-1:0]    op_code,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] acc_out,
  input logic              flag_s,
  input logic              flag_z,
  input logic              flag_ac,
  input logic              flag_p,
  input logic              flag_cy,
  input logic              acc_we
);
  logic [4:0] flags_v;
  assign flags_v = {flag_s, flag_z, flag_ac, flag_p, flag_cy};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_out == '0) && (flags_v == 5'd0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(acc_out) && $stable(flags_v));

  // R2
  acc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(acc_out));

  // R3
  and_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_AND) |=> acc_out == ($past(acc_out) & $past(operand)));

  // R4
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= OP_XOR) |=>
      !flag_cy && flag_ac && (flag_z == (acc_out == '0)) && (flag_s == acc_out[DATA_W-1]));

  // R5
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=> $stable(acc_out) && !(flag_z && flag_cy));

  // R9
  rot_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= OP_RLC && op_code <= OP_RAR) |=>
      $stable(flag_s) && $stable(flag_z) && $stable(flag_p) && $stable(flag_ac));

  // R10
  cma_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMA) |=> (acc_out == ~$past(acc_out)) && $stable(flags_v));

  // R11
  cmc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMC) |=> (flag_cy != $past(flag_cy)) && $stable(acc_out));

  // R11
  stc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_STC) |=> flag_cy && $stable(acc_out) && $stable(flag_z));
endmodule

bind acc_logic_unit acc_logic_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/acc_logic_unit_test.sv
`timescale 1ns/1ps
module acc_logic_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_out;
  logic       flag_s, flag_z, flag_ac, flag_p, flag_cy;

  int checks = 0;
  int errors = 0;

  // bench model of the visible state
  logic [7:0] m_acc = 8'd0;
  logic       m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

  always #2.5 clk = ~clk;

  acc_logic_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc_out(acc_out), .flag_s(flag_s), .flag_z(flag_z),
    .flag_ac(flag_ac), .flag_p(flag_p), .flag_cy(flag_cy)
  );

  function automatic logic even_ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return (n % 2) == 0;
  endfunction

  function automatic void set_szp(input logic [7:0] v);
    m_s = (v >= 8'd128);
    m_z = (v == 8'd0);
    m_p = even_ones(v);
  endfunction

  task automatic model(input logic [3:0] op, input logic [7:0] v);
    logic [7:0] r;
    logic       c;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        for (int i = 0; i < 8; i++)
          r[i] = (op == 4'd0) ? (m_acc[i] && v[i]) :
                 (op == 4'd1) ? (m_acc[i] || v[i]) : (m_acc[i] != v[i]);
        m_acc = r; set_szp(r); m_cy = 0; m_ac = 1;
      end
      4'd3: begin
        r = 8'((int'(m_acc) - int'(v) + 256) % 256);
        set_szp(r);
        m_cy = (int'(m_acc) < int'(v));
        m_ac = ((int'(m_acc) % 16) < (int'(v) % 16));
      end
      4'd4: begin c = m_acc >= 128; m_acc = 8'((int'(m_acc) * 2) % 256 + int'(c)); m_cy = c; end
      4'd5: begin c = m_acc[0]; m_acc = 8'(int'(m_acc) / 2 + (c ? 128 : 0)); m_cy = c; end
      4'd6: begin c = m_acc >= 128; m_acc = 8'((int'(m_acc) * 2) % 256 + int'(m_cy)); m_cy = c; end
      4'd7: begin c = m_acc[0]; m_acc = 8'(int'(m_acc) / 2 + (m_cy ? 128 : 0)); m_cy = c; end
      4'd8: m_acc = 8'(255 - int'(m_acc));
      4'd9: m_cy = !m_cy;
      4'd10: m_cy = 1;
      default: ;
    endcase
  endtask

  task automatic check_val(input string tag, input string what,
                           input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check_val(tag, "acc", acc_out, m_acc);
    check_val(tag, "flags szapc", {3'b0, flag_s, flag_z, flag_ac, flag_p, flag_cy},
              {3'b0, m_s, m_z, m_ac, m_p, m_cy});
  endtask

  // drive at negedge, one posedge updates, sample at the next negedge
  task automatic step(input logic [3:0] op, input logic [7:0] v, input logic en);
    @(negedge clk);
    op_valid = en; op_code = op; operand = v;
    @(negedge clk);
    op_valid = 1'b0;
    if (en) model(op, v);
  endtask

  task automatic load_acc(input logic [7:0] v);
    step(4'd0, 8'h00, 1'b1);
    step(4'd1, v, 1'b1);
  endtask

  task automatic t_reset;
    load_acc(8'h5A);
    step(4'd10, 8'h00, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    check_all("R1");
  endtask

  task automatic t_logic;
    load_acc(8'hF0);            check_all("R3");
    step(4'd0, 8'h3C, 1'b1);    check_val("R3", "and", acc_out, 8'h30); check_all("R4");
    step(4'd2, 8'h30, 1'b1);    check_val("R4", "zero", {7'b0, flag_z}, 8'h01); check_all("R4");
    step(4'd1, 8'h83, 1'b1);    check_val("R4", "parity", {7'b0, flag_p}, 8'h00); check_all("R3");
    step(4'd10, 8'h00, 1'b1);
    step(4'd2, 8'hFF, 1'b1);    check_val("R4", "carry", {7'b0, flag_cy}, 8'h00); check_all("R4");
  endtask

  task automatic t_compare;
    load_acc(8'h42);
    step(4'd3, 8'h42, 1'b1);    check_val("R5", "zcy", {6'b0, flag_z, flag_cy}, 8'h02); check_all("R5");
    step(4'd3, 8'h50, 1'b1);    check_val("R5", "zcy", {6'b0, flag_z, flag_cy}, 8'h01); check_all("R5");
    step(4'd3, 8'h10, 1'b1);    check_val("R5", "zcy", {6'b0, flag_z, flag_cy}, 8'h00); check_all("R5");
    step(4'd3, 8'h0F, 1'b1);    check_val("R6", "ac", {7'b0, flag_ac}, 8'h01); check_all("R6");
    step(4'd3, 8'hC1, 1'b1);    check_all("R6");
    check_val("R5", "acc kept", acc_out, 8'h42);
  endtask

  task automatic t_rotate;
    load_acc(8'h81);
    step(4'd4, 8'h00, 1'b1);    check_val("R7", "rlc", acc_out, 8'h03); check_all("R7");
    step(4'd5, 8'h00, 1'b1);    check_val("R7", "rrc", acc_out, 8'h81); check_all("R7");
    step(4'd5, 8'h00, 1'b1);    check_all("R7");
    load_acc(8'h80);
    step(4'd6, 8'h00, 1'b1);    check_val("R8", "ral", acc_out, 8'h00); check_all("R8");
    step(4'd6, 8'h00, 1'b1);    check_val("R8", "ral", acc_out, 8'h01); check_all("R8");
    step(4'd7, 8'h00, 1'b1);    check_all("R8");
    step(4'd7, 8'h00, 1'b1);    check_val("R8", "rar", acc_out, 8'h80); check_all("R8");
    load_acc(8'h00);
    step(4'd10, 8'h00, 1'b1);
    step(4'd7, 8'h00, 1'b1);    check_val("R9", "z kept", {7'b0, flag_z}, 8'h01); check_all("R9");
  endtask

  task automatic t_misc;
    load_acc(8'h6C);
    step(4'd8, 8'h00, 1'b1);    check_val("R10", "cma", acc_out, 8'h93); check_all("R10");
    step(4'd9, 8'h00, 1'b1);    check_val("R11", "cmc", {7'b0, flag_cy}, 8'h01); check_all("R11");
    step(4'd9, 8'h00, 1'b1);    check_all("R11");
    step(4'd10, 8'h00, 1'b1);   check_all("R11");
    step(4'd10, 8'h00, 1'b1);   check_all("R11");
  endtask

  task automatic t_hold;
    load_acc(8'hA5);
    step(4'd0, 8'h00, 1'b0);    check_all("R2");
    step(4'd8, 8'h00, 1'b0);    check_all("R2");
    for (int k = 11; k < 16; k++) begin
      step(4'(k), 8'h0F, 1'b1); check_all("R2");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");
    t_logic();
    t_compare();
    t_rotate();
    t_misc();
    t_hold();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule